// File: doc/BRIEF.md
# Shared-Datapath 32-bit Integer ALU

This block is a purely combinational integer unit for a simple 32-bit processor datapath. It takes two operands, a 4-bit operation code and a 5-bit shift distance. It returns a 32-bit result and a signed-overflow flag. It covers three shift kinds, addition, subtraction, four bitwise functions and four compare functions. Several opcode bits are don't-care for some functions, so the map has 16 codes but only 13 distinct functions.

Hardware is shared. One adder serves both addition and subtraction; subtraction inverts the second operand and sets the carry-in. One left shifter serves all shifts; right shifts reverse the bit order of the operand before the shifter and of the result after it. The result is chosen by two levels of 2-way selection driven straight from opcode bits. There is no 16-way multiplexer and no full opcode decoder.

Top module: `alu32_core`

## Requirements
- R1: Op 0000 and 0001 (bit 0 ignored) give res = B shifted left by shamt with zeros entering at bit 0, and ovf = 0.
- R2: Op 0100 gives res = B shifted right by shamt with zeros entering at bit 31, and ovf = 0.
- R3: Op 0101 gives res = B shifted right by shamt with copies of B[31] entering at the top, and ovf = 0.
- R4: Op 0010 and 0011 give res = A + B modulo 2^32. ovf = 1 exactly when the signed two's-complement sum does not fit in 32 bits. The wrapped sum is still driven when that happens.
- R5: Op 0110 and 0111 give res = A - B modulo 2^32. ovf = 1 exactly when the signed difference does not fit in 32 bits, and res still holds the wrapped difference.
- R6: Op 1000, 1010, 1100 and 1110 give the bitwise AND, OR, XOR and NOR of A and B, with ovf = 0.
- R7: Op 1001 puts 1 in res[0] when A equals B, and Op 1011 puts 1 there when they differ. res[31:1] is zero.
- R8: With B = 0, Op 1101 sets res[0] when A is signed-positive, and Op 1111 sets res[0] when A is signed zero or negative. res[31:1] is zero.
- R9: ovf is 0 for every opcode outside the add and subtract codes.
- R10: shamt has no effect on any non-shift operation, and A has no effect on any shift.
- R11: A shift distance of 0 returns B unchanged for all three shift kinds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 32 | First operand A |
| opb_i | input | 32 | Second operand B; also the value that is shifted |
| op_i | input | 4 | Operation code |
| shamt_i | input | 5 | Unsigned shift distance, 0 to 31 |
| res_o | output | 32 | Result |
| ovf_o | output | 1 | Signed overflow, add and subtract only |

## Verification
The bench targets the signed overflow edges: the largest positive value plus one, the most negative value plus itself, and subtraction of the most negative value. A wrong overflow term would miss one of these or raise a false flag on an unsigned carry out such as -1 + 1. It sweeps every shift distance for each shift kind. A bad reversal or stage order would show up as a mirrored or misplaced field, and a wrong fill would put zeros where sign copies belong. It also checks that the don't-care opcode bits, the unused operand and the shift distance outside shifts leave the result unchanged. A decoder that keyed on the wrong bit would switch function or flag overflow there.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, control record and helpers for the integer unit.
// Assumes the opcode layout: bit3 splits datapath/bitwise-compare,
// bit1 splits shift/arith, bit0 splits bitwise/compare in the upper half.
package alu_pkg;

    parameter int unsigned ALU_W = 32;
    localparam int unsigned ALU_SHW = $clog2(ALU_W);
    localparam int unsigned OP_W = 4;

    // Control fields pulled directly from opcode bits.
    typedef struct packed {
        logic       upper_half;   // bitwise or compare group
        logic       use_adder;    // arith rather than shift (lower half)
        logic       use_cmp;      // compare rather than bitwise (upper half)
        logic       sub_en;       // subtract in the adder
        logic       shr_en;       // right shift
        logic       shr_arith;    // sign fill on right shift
        logic [1:0] fsel;         // function within bitwise/compare group
    } alu_ctrl_t;

    // Map opcode bits to control fields with no full decode.
    function automatic alu_ctrl_t decode_op(input logic [OP_W-1:0] op);
        alu_ctrl_t c;
        c.upper_half = op[3];
        c.use_adder  = op[1];
        c.use_cmp    = op[0];
        c.sub_en     = op[2];
        c.shr_en     = op[2];
        c.shr_arith  = op[0];
        c.fsel       = op[2:1];
        return c;
    endfunction

endpackage

// File: rtl/alu_lshift.sv
`timescale 1ns/1ps
// Module: staged left shifter with a fill bit.
// Shifts din left by shamt; vacated low bits take the value of fill.
// Stages run from the largest power of two down to one.
module alu_lshift #(
    parameter int W = 32,
    localparam int SHW = $clog2(W)
) (
    input  logic [W-1:0]   din,
    input  logic [SHW-1:0] shamt,
    input  logic           fill,
    output logic [W-1:0]   dout
);

    logic [W-1:0] stage [0:SHW];

    assign stage[0] = din;

    // One conditional shift per bit of the shift distance.
    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int IDX = SHW - 1 - k;
        localparam int AMT = 1 << IDX;
        logic [W-1:0] shifted;
        assign shifted      = {stage[k][W-1-AMT:0], {AMT{fill}}};
        assign stage[k+1]   = shamt[IDX] ? shifted : stage[k];
    end

    assign dout = stage[SHW];

endmodule

// File: rtl/alu_shift_unit.sv
`timescale 1ns/1ps
// Module: all three shift kinds around one left shifter.
// Right shifts reverse the operand, shift left, then reverse back.
// The fill bit is zero except for an arithmetic right shift.
module alu_shift_unit #(
    parameter int W = 32,
    localparam int SHW = $clog2(W)
) (
    input  logic [W-1:0]   val,
    input  logic [SHW-1:0] shamt,
    input  logic           shr_en,
    input  logic           shr_arith,
    output logic [W-1:0]   dout
);

    logic [W-1:0] val_rev;
    logic [W-1:0] sh_in;
    logic [W-1:0] sh_out;
    logic [W-1:0] sh_out_rev;
    logic         fill;

    // Reverse the operand bit order for right shifts.
    for (genvar i = 0; i < W; i++) begin : g_rev_in
        assign val_rev[i] = val[W-1-i];
    end

    // Reverse the shifter output bit order for right shifts.
    for (genvar i = 0; i < W; i++) begin : g_rev_out
        assign sh_out_rev[i] = sh_out[W-1-i];
    end

    assign sh_in = shr_en ? val_rev : val;
    assign fill  = shr_en & shr_arith & val[W-1];

    alu_lshift #(.W(W)) i_lshift (
        .din   (sh_in),
        .shamt (shamt),
        .fill  (fill),
        .dout  (sh_out)
    );

    assign dout = shr_en ? sh_out_rev : sh_out;

endmodule

// File: rtl/alu_addsub.sv
`timescale 1ns/1ps
// Module: one adder for add and subtract with signed overflow.
// Subtract feeds the inverted second operand and a carry-in of one.
// Overflow: both adder inputs share a sign that the sum does not.
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub_en,
    output logic [W-1:0] sum,
    output logic         ovf
);

    logic [W-1:0] b_eff;
    logic [W:0]   total;

    assign b_eff = sub_en ? ~b : b;
    assign total = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub_en};
    assign sum   = total[W-1:0];
    assign ovf   = (a[W-1] == b_eff[W-1]) & (sum[W-1] != a[W-1]);

endmodule

// File: rtl/alu_bitwise.sv
`timescale 1ns/1ps
// Module: bitwise functions selected by two bits.
// fsel 00 AND, 01 OR, 10 XOR, 11 NOR. Also exports the XOR for compare.
module alu_bitwise #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   fsel,
    output logic [W-1:0] dout,
    output logic [W-1:0] diff
);

    logic [W-1:0] or_v;

    assign or_v = a | b;
    assign diff = a ^ b;

    // Choose one of the four bitwise functions.
    always_comb begin
        unique case (fsel)
            2'b00:   dout = a & b;
            2'b01:   dout = or_v;
            2'b10:   dout = diff;
            default: dout = ~or_v;
        endcase
    end

endmodule

// File: rtl/alu_compare.sv
`timescale 1ns/1ps
// Module: compare functions producing a single bit in the result LSB.
// fsel 00 equal, 01 not-equal, 10 greater-than, 11 less-or-equal.
// Ordering tests assume the second operand is zero, so only the sign
// and zero-ness of the first operand matter.
module alu_compare #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] diff,
    input  logic [1:0]   fsel,
    output logic [W-1:0] dout
);

    logic same;
    logic a_zero;
    logic a_pos;
    logic bit_res;

    assign same   = ~|diff;
    assign a_zero = ~|a;
    assign a_pos  = ~a[W-1] & ~a_zero;

    // Pick the compare outcome for the requested function.
    always_comb begin
        unique case (fsel)
            2'b00:   bit_res = same;
            2'b01:   bit_res = ~same;
            2'b10:   bit_res = a_pos;
            default: bit_res = ~a_pos;
        endcase
    end

    assign dout = {{(W-1){1'b0}}, bit_res};

endmodule

// File: rtl/alu32_core.sv
`timescale 1ns/1ps
// Module: combinational integer ALU top.
// Computes shift, add/sub, bitwise and compare results in parallel from
// one shifter and one adder, then selects with two levels of 2-way muxes
// keyed on opcode bits 1/0 and then bit 3. Overflow only for add/sub.
module alu32_core #(
    parameter int W = alu_pkg::ALU_W,
    localparam int SHW = $clog2(W)
) (
    input  logic [W-1:0]   opa_i,
    input  logic [W-1:0]   opb_i,
    input  logic [3:0]     op_i,
    input  logic [SHW-1:0] shamt_i,
    output logic [W-1:0]   res_o,
    output logic           ovf_o
);

    import alu_pkg::*;

    alu_ctrl_t    ctrl;
    logic [W-1:0] shift_res;
    logic [W-1:0] arith_res;
    logic         arith_ovf;
    logic [W-1:0] bit_res;
    logic [W-1:0] bit_diff;
    logic [W-1:0] cmp_res;
    logic [W-1:0] lower_res;
    logic [W-1:0] upper_res;

    assign ctrl = decode_op(op_i);

    alu_shift_unit #(.W(W)) i_shift (
        .val       (opb_i),
        .shamt     (shamt_i),
        .shr_en    (ctrl.shr_en),
        .shr_arith (ctrl.shr_arith),
        .dout      (shift_res)
    );

    alu_addsub #(.W(W)) i_addsub (
        .a      (opa_i),
        .b      (opb_i),
        .sub_en (ctrl.sub_en),
        .sum    (arith_res),
        .ovf    (arith_ovf)
    );

    alu_bitwise #(.W(W)) i_bitwise (
        .a    (opa_i),
        .b    (opb_i),
        .fsel (ctrl.fsel),
        .dout (bit_res),
        .diff (bit_diff)
    );

    alu_compare #(.W(W)) i_compare (
        .a    (opa_i),
        .diff (bit_diff),
        .fsel (ctrl.fsel),
        .dout (cmp_res)
    );

    // First selection level inside each half of the opcode map.
    assign lower_res = ctrl.use_adder ? arith_res : shift_res;
    assign upper_res = ctrl.use_cmp   ? cmp_res   : bit_res;

    // Second level picks the half; overflow gated to the arith codes.
    assign res_o = ctrl.upper_half ? upper_res : lower_res;
    assign ovf_o = ~ctrl.upper_half & ctrl.use_adder & arith_ovf;

endmodule

// File: rtl/alu32_core_chk.sv
`timescale 1ns/1ps
// Module: property checker for the integer ALU, attached by bind.
// Combinational block, so the checks are immediate assertions
// evaluated whenever the ports settle.
module alu32_core_chk #(
    parameter int W = 32,
    localparam int SHW = $clog2(W)
) (
    input logic [W-1:0]   opa_i,
    input logic [W-1:0]   opb_i,
    input logic [3:0]     op_i,
    input logic [SHW-1:0] shamt_i,
    input logic [W-1:0]   res_o,
    input logic           ovf_o
);

    logic is_arith;
    logic is_shift;
    logic [W-1:0] exp_sum;
    logic [W-1:0] exp_dif;

    assign is_arith = (op_i[3] == 1'b0) && op_i[1];
    assign is_shift = (op_i[3] == 1'b0) && !op_i[1];
    assign exp_sum  = opa_i + opb_i;
    assign exp_dif  = opa_i - opb_i;

    // Check port relations for every settled input combination.
    always_comb begin
        if (!is_arith)
            p_no_overflow_r9: assert (ovf_o == 1'b0);
        if (op_i[3] && op_i[0])
            p_cmp_upper_r7: assert (res_o[W-1:1] == '0);
        if (op_i == 4'b1001)
            p_equal_r7: assert (res_o[0] == (opa_i == opb_i));
        if (is_shift && shamt_i == '0)
            p_shift_zero_r11: assert (res_o == opb_i);
        if (op_i[3:1] == 3'b001)
            p_add_wrap_r4: assert (res_o == exp_sum);
        if (op_i[3:1] == 3'b011)
            p_sub_wrap_r5: assert (res_o == exp_dif);
        if (is_arith && ovf_o)
            p_ovf_sign_r4: assert (res_o[W-1] != opa_i[W-1]);
        if (op_i == 4'b0101)
            p_sra_sign_r3: assert (res_o[W-1] == opb_i[W-1]);
        if (op_i == 4'b0100 && shamt_i != '0)
            p_srl_top_r2: assert (res_o[W-1] == 1'b0);
    end

endmodule

bind alu32_core alu32_core_chk #(.W(W)) i_chk (
    .opa_i   (opa_i),
    .opb_i   (opb_i),
    .op_i    (op_i),
    .shamt_i (shamt_i),
    .res_o   (res_o),
    .ovf_o   (ovf_o)
);

// File: tb/test_alu32_core.sv
`timescale 1ns/1ps
// Bench: vector table walk, then shift sweeps, don't-care and corner tests.
module test_alu32_core;

    typedef struct packed {
        logic [3:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [4:0]  sa;
        logic [31:0] c;
        logic        v;
    } vec_t;

    localparam int NVEC = 24;
    localparam vec_t VECS [NVEC] = '{
        '{4'b0000, 32'hFFFFFFFF, 32'h00000001, 5'd31, 32'h80000000, 1'b0}, // R1
        '{4'b0001, 32'h00000000, 32'h12345678, 5'd4,  32'h23456780, 1'b0}, // R1
        '{4'b0010, 32'h7FFFFFFF, 32'h00000001, 5'd7,  32'h80000000, 1'b1}, // R4
        '{4'b0011, 32'hFFFFFFFF, 32'h00000001, 5'd0,  32'h00000000, 1'b0}, // R4
        '{4'b0010, 32'h80000000, 32'h80000000, 5'd3,  32'h00000000, 1'b1}, // R4
        '{4'b0100, 32'h00000000, 32'h80000000, 5'd31, 32'h00000001, 1'b0}, // R2
        '{4'b0101, 32'h00000000, 32'h80000000, 5'd31, 32'hFFFFFFFF, 1'b0}, // R3
        '{4'b0101, 32'hFFFFFFFF, 32'h70000000, 5'd4,  32'h07000000, 1'b0}, // R3
        '{4'b0110, 32'h80000000, 32'h00000001, 5'd9,  32'h7FFFFFFF, 1'b1}, // R5
        '{4'b0111, 32'h00000005, 32'h00000007, 5'd0,  32'hFFFFFFFE, 1'b0}, // R5
        '{4'b0110, 32'h00000000, 32'h80000000, 5'd0,  32'h80000000, 1'b1}, // R5
        '{4'b0110, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0,  32'h80000000, 1'b1}, // R5
        '{4'b1000, 32'hF0F0F0F0, 32'hFF00FF00, 5'd5,  32'hF000F000, 1'b0}, // R6
        '{4'b1010, 32'hF0F0F0F0, 32'hFF00FF00, 5'd0,  32'hFFF0FFF0, 1'b0}, // R6
        '{4'b1100, 32'hF0F0F0F0, 32'hFF00FF00, 5'd0,  32'h0FF00FF0, 1'b0}, // R6
        '{4'b1110, 32'hF0F0F0F0, 32'hFF00FF00, 5'd0,  32'h000F000F, 1'b0}, // R6
        '{4'b1001, 32'hDEADBEEF, 32'hDEADBEEF, 5'd0,  32'h00000001, 1'b0}, // R7
        '{4'b1001, 32'h00000001, 32'h00000002, 5'd0,  32'h00000000, 1'b0}, // R7
        '{4'b1011, 32'hDEADBEEF, 32'hDEADBEEE, 5'd0,  32'h00000001, 1'b0}, // R7
        '{4'b1101, 32'h00000001, 32'h00000000, 5'd0,  32'h00000001, 1'b0}, // R8
        '{4'b1101, 32'h00000000, 32'h00000000, 5'd0,  32'h00000000, 1'b0}, // R8
        '{4'b1101, 32'h80000000, 32'h00000000, 5'd0,  32'h00000000, 1'b0}, // R8
        '{4'b1111, 32'h80000000, 32'h00000000, 5'd0,  32'h00000001, 1'b0}, // R8
        '{4'b1111, 32'h00000000, 32'h00000000, 5'd0,  32'h00000001, 1'b0}  // R8
    };

    logic        clk;
    logic        rst_n;
    logic [31:0] opa;
    logic [31:0] opb;
    logic [3:0]  op;
    logic [4:0]  shamt;
    logic [31:0] res;
    logic        ovf;

    int checks;
    int errors;
    bit done;

    alu32_core i_alu32_core (
        .opa_i   (opa),
        .opb_i   (opb),
        .op_i    (op),
        .shamt_i (shamt),
        .res_o   (res),
        .ovf_o   (ovf)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    // Drive one operation after a rising edge; outputs read at the falling edge.
    task automatic apply(input logic [3:0] o, input logic [31:0] a,
                         input logic [31:0] b, input logic [4:0] s);
        @(posedge clk);
        op = o; opa = a; opb = b; shamt = s;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] exp_c,
                         input logic exp_v);
        checks++;
        if (res !== exp_c || ovf !== exp_v) begin
            errors++;
            $display("FAIL %s: op=%b got c=%h v=%b expected c=%h v=%b",
                     req, op, res, ovf, exp_c, exp_v);
        end
    endtask

    // Shift model from the requirements (R1, R2, R3).
    function automatic logic [31:0] model_shift(input logic [3:0] o,
            input logic [31:0] b, input logic [4:0] s);
        if (o[2] == 1'b0) return b << s;
        if (o[0] == 1'b0) return b >> s;
        return 32'($signed(b) >>> s);
    endfunction

    initial begin
        logic [31:0] ref_c;
        logic        ref_v;
        checks = 0; errors = 0; done = 0;
        rst_n = 1'b0;
        op = '0; opa = '0; opb = '0; shamt = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset state", 32'h0, 1'b0);
        rst_n = 1'b1;

        // Table walk.
        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].sa);
            check($sformatf("vector %0d (R1-table)", i), VECS[i].c, VECS[i].v);
        end

        // Every shift distance, all three kinds, two patterns (R1 R2 R3).
        for (int s = 0; s < 32; s++) begin
            apply(4'b0000, 32'h5A5A5A5A, 32'h8421F00D, 5'(s));
            check("R1 sll sweep", model_shift(4'b0000, 32'h8421F00D, 5'(s)), 1'b0);
            apply(4'b0100, 32'hFFFFFFFF, 32'h8421F00D, 5'(s));
            check("R2 srl sweep", model_shift(4'b0100, 32'h8421F00D, 5'(s)), 1'b0);
            apply(4'b0101, 32'h00000000, 32'h8421F00D, 5'(s));
            check("R3 sra sweep neg", model_shift(4'b0101, 32'h8421F00D, 5'(s)), 1'b0);
            apply(4'b0101, 32'h12345678, 32'h7F0000FF, 5'(s));
            check("R3 sra sweep pos", model_shift(4'b0101, 32'h7F0000FF, 5'(s)), 1'b0);
        end

        // Zero distance passes B through (R11).
        apply(4'b0100, 32'h0, 32'hCAFEF00D, 5'd0);
        check("R11 srl zero", 32'hCAFEF00D, 1'b0);
        apply(4'b0101, 32'h0, 32'hCAFEF00D, 5'd0);
        check("R11 sra zero", 32'hCAFEF00D, 1'b0);
        apply(4'b0001, 32'h0, 32'hCAFEF00D, 5'd0);
        check("R11 sll zero", 32'hCAFEF00D, 1'b0);

        // Shift distance ignored by add, sub, logic, compare (R10).
        for (int s = 0; s < 32; s += 5) begin
            apply(4'b0011, 32'h00001234, 32'h00000FFF, 5'(s));
            check("R10 add ignores shamt", 32'h00002233, 1'b0);
            apply(4'b0111, 32'h00001234, 32'h00000FFF, 5'(s));
            check("R10 sub ignores shamt", 32'h00000235, 1'b0);
            apply(4'b1100, 32'h00001234, 32'h00000FFF, 5'(s));
            check("R10 xor ignores shamt", 32'h00001DCB, 1'b0);
            apply(4'b1011, 32'h00001234, 32'h00001234, 5'(s));
            check("R10 ne ignores shamt", 32'h00000000, 1'b0);
        end

        // Overflow corners for add and sub, both don't-care codes (R4 R5 R9).
        apply(4'b0011, 32'h7FFFFFFF, 32'h7FFFFFFF, 5'd0);
        check("R4 pos+pos overflow", 32'hFFFFFFFE, 1'b1);
        apply(4'b0010, 32'h80000000, 32'hFFFFFFFF, 5'd0);
        check("R4 neg+neg overflow", 32'h7FFFFFFF, 1'b1);
        apply(4'b0010, 32'h7FFFFFFF, 32'h80000000, 5'd0);
        check("R4 mixed no overflow", 32'hFFFFFFFF, 1'b0);
        apply(4'b0111, 32'h80000000, 32'h80000000, 5'd0);
        check("R5 min-min no overflow", 32'h00000000, 1'b0);
        apply(4'b0111, 32'hFFFFFFFF, 32'h7FFFFFFF, 5'd0);
        check("R5 -1-max no overflow", 32'h80000000, 1'b0);
        apply(4'b1000, 32'h7FFFFFFF, 32'h7FFFFFFF, 5'd0);
        check("R9 and no flag", 32'h7FFFFFFF, 1'b0);
        apply(4'b0000, 32'h7FFFFFFF, 32'h40000000, 5'd1);
        check("R9 sll no flag", 32'h80000000, 1'b0);

        // Random add/sub against a reference (R4 R5).
        for (int i = 0; i < 200; i++) begin
            logic [31:0] ra;
            logic [31:0] rb;
            logic [3:0]  ro;
            ra = $urandom; rb = $urandom;
            ro = (i % 2 == 0) ? 4'b0010 : 4'b0110;
            ro[0] = i[1];
            apply(ro, ra, rb, 5'($urandom));
            if (ro[2]) begin
                ref_c = ra - rb;
                ref_v = (ra[31] != rb[31]) && (ref_c[31] != ra[31]);
                check("R5 random sub", ref_c, ref_v);
            end else begin
                ref_c = ra + rb;
                ref_v = (ra[31] == rb[31]) && (ref_c[31] != ra[31]);
                check("R4 random add", ref_c, ref_v);
            end
        end

        // Operand A has no effect on shifts (R10).
        apply(4'b0101, 32'hFFFFFFFF, 32'h00F00000, 5'd8);
        check("R10 shift ignores A", 32'h0000F000, 1'b0);

        // Compare results on random equal/unequal pairs (R7).
        for (int i = 0; i < 20; i++) begin
            logic [31:0] ra;
            ra = $urandom;
            apply(4'b1001, ra, ra, 5'd0);
            check("R7 eq equal", 32'h1, 1'b0);
            apply(4'b1011, ra, ra ^ 32'h00010000, 5'd0);
            check("R7 ne differ", 32'h1, 1'b0);
        end

        // Ordering with B zero at sign boundaries (R8).
        apply(4'b1101, 32'h7FFFFFFF, 32'h0, 5'd0);
        check("R8 gt max", 32'h1, 1'b0);
        apply(4'b1111, 32'hFFFFFFFF, 32'h0, 5'd0);
        check("R8 le minus one", 32'h1, 1'b0);
        apply(4'b1111, 32'h00000001, 32'h0, 5'd0);
        check("R8 le one", 32'h0, 1'b0);

        // Logic with random operands (R6).
        for (int i = 0; i < 20; i++) begin
            logic [31:0] ra;
            logic [31:0] rb;
            ra = $urandom; rb = $urandom;
            apply(4'b1110, ra, rb, 5'd0);
            check("R6 nor random", ~(ra | rb), 1'b0);
            apply(4'b1000, ra, rb, 5'd0);
            check("R6 and random", ra & rb, 1'b0);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule